// File: doc/BRIEF.md
# Accumulator ALU with Program Status Word

This block is the byte-wide arithmetic unit of an accumulator-style microcontroller core, together with the program status word that records what the last arithmetic step did. On each clock where an operation is presented, it takes the current accumulator, a second operand and the B register. It performs one of five operations: add, add with carry, subtract with borrow, multiply or divide. The results and their write strobes come out one cycle later, so the surrounding core can write them back to its accumulator and B register. The carry, auxiliary-carry and overflow flags are updated in the same cycle.

The status word also holds two general-purpose user flags and a two-bit register-bank select. The block turns the bank select into the base address of the active working-register window in internal RAM. A parity bit always tracks the number of ones in the accumulator. Software can write the status word through a dedicated write port. When that write meets an arithmetic operation in the same cycle, the arithmetic result wins for the three arithmetic flags.

Top module: `accum_alu`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `psw_out` is 0x00, `bank_base` is 0 and both result write strobes are low.
- R2: With `op_valid` high, opcode 0 (add) writes `acc_in + opnd_in` modulo 256 to `res_acc`, and opcode 1 (add with carry) writes `acc_in + opnd_in + CY` modulo 256. CY (status bit 7) becomes the carry out of bit 7, and AC (status bit 6) becomes the carry out of bit 3.
- R3: Opcode 2 (subtract with borrow) writes `acc_in - opnd_in - CY` modulo 256 to `res_acc`. CY becomes 1 exactly when the true difference is negative, and AC becomes 1 exactly when the low nibble needs a borrow from bit 4.
- R4: For opcodes 0, 1 and 2, OV (status bit 2) becomes 1 exactly when the two's-complement result lies outside -128..127.
- R5: Opcode 3 (multiply) writes the low byte of `acc_in * b_in` to `res_acc` and the high byte to `res_b`. OV becomes 1 when the product exceeds 255. CY and AC become 0.
- R6: Opcode 4 (divide) with `b_in` non-zero writes the quotient `acc_in / b_in` to `res_acc` and the remainder to `res_b`, and clears CY, AC and OV.
- R7: Opcode 4 with `b_in` zero sets OV, clears CY and AC, and leaves both write strobes low.
- R8: PARITY (status bit 0) equals the XOR of the eight bits of `acc_in` sampled at the previous clock edge. A status-word write never sets it.
- R9: `psw_we` loads status bits 7..1 from `psw_wdata` in the layout CY(7), AC(6), F0(5), RS1(4), RS0(3), OV(2), F1(1). The new value is visible one cycle later.
- R10: When a status-word write and a valid arithmetic operation fall in the same cycle, CY, AC and OV take the arithmetic values, while F0, F1, RS1 and RS0 take the written values. The carry used by add-with-carry and subtract-with-borrow is the value before that cycle.
- R11: `bank_base` equals {RS1,RS0} times 8, so the select values 0, 1, 2 and 3 give working registers at 0x00, 0x08, 0x10 and 0x18.
- R12: F0, F1, RS1 and RS0 change only through `psw_we`. With `op_valid` low, or with opcodes 5 to 7, CY, AC and OV keep their values and no result strobe rises.
- R13: `res_acc_we` is high for one cycle after each accepted add, add-with-carry, subtract, multiply or non-zero divide. `res_b_we` is high only after a multiply or a non-zero divide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation select: 0 add, 1 add with carry, 2 subtract with borrow, 3 multiply, 4 divide |
| acc_in | input | DATA_W | Current accumulator value |
| opnd_in | input | DATA_W | Second operand for add and subtract |
| b_in | input | DATA_W | Current B register value (multiplier or divisor) |
| psw_we | input | 1 | Status-word write enable |
| psw_wdata | input | 8 | Status-word write value (bit 0 ignored) |
| res_acc | output | DATA_W | Result destined for the accumulator |
| res_b | output | DATA_W | Result destined for B |
| res_acc_we | output | 1 | Accumulator write strobe |
| res_b_we | output | 1 | B write strobe |
| psw_out | output | 8 | Program status word |
| bank_base | output | RAM_AW | Base address of the selected working-register bank |

## Verification
The bench builds the block with its defaults: an 8-bit data path, an 8-bit RAM address and banks of 8 registers. This matches the byte arithmetic of the reference model. The sign boundaries 0x7F/0x80, the nibble boundary and the 0xFF wrap can therefore be reached directly by named vectors, and random operands cover the full range. The four bank windows, the boundary of the 255 product limit and the zero divisor all fall within a few directed cycles. A long random run then mixes status-word writes with operations, so the same-cycle priority and the chaining of the carry are exercised many times.

// File: rtl/accum_alu_pkg.sv
package accum_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUBB = 3'd2,
    OP_MUL  = 3'd3,
    OP_DIV  = 3'd4
  } alu_op_e;

  // status word bit positions (decoded by neighbours, so fixed)
  localparam int PSW_CY  = 7;
  localparam int PSW_AC  = 6;
  localparam int PSW_F0  = 5;
  localparam int PSW_RS1 = 4;
  localparam int PSW_RS0 = 3;
  localparam int PSW_OV  = 2;
  localparam int PSW_F1  = 1;
  localparam int PSW_P   = 0;
  localparam int PSW_W   = 8;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } arith_flags_t;

endpackage

// File: rtl/aa_addsub.sv
module aa_addsub #(
  parameter int W = 8
) (
  input  logic         sub,
  input  logic         cin,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         cy,
  output logic         ac,
  output logic         ov
);
  localparam int H = W / 2;

  logic [W-1:0] b_eff;
  logic         c_eff;
  logic [W:0]   full;
  logic [H:0]   low;

  // one adder serves both directions: a - b - c == a + ~b + ~c
  always_comb begin
    b_eff = sub ? ~b : b;
    c_eff = sub ? ~cin : cin;
    full  = {1'b0, a} + {1'b0, b_eff} + (W+1)'(c_eff);
    low   = {1'b0, a[H-1:0]} + {1'b0, b_eff[H-1:0]} + (H+1)'(c_eff);
    res   = full[W-1:0];
    cy    = sub ? ~full[W] : full[W];
    ac    = sub ? ~low[H] : low[H];
    ov    = (a[W-1] == b_eff[W-1]) && (full[W-1] != a[W-1]);
  end

endmodule

// File: rtl/aa_muldiv.sv
module aa_muldiv #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   d,
  output logic [2*W-1:0] prod,
  output logic [W-1:0]   quo,
  output logic [W-1:0]   rem,
  output logic           div_zero
);
  logic [W-1:0] rem_s [0:W];

  assign prod     = {{W{1'b0}}, a} * {{W{1'b0}}, d};
  assign div_zero = (d == '0);
  assign rem_s[0] = '0;

  // restoring division, one stage per dividend bit, MSB first
  for (genvar i = 0; i < W; i++) begin : g_stage
    logic [W:0] trial;
    logic       fit;
    assign trial          = {rem_s[i], a[W-1-i]};
    assign fit            = (trial >= {1'b0, d});
    assign quo[W-1-i]     = fit;
    assign rem_s[i+1]     = fit ? W'(trial - {1'b0, d}) : trial[W-1:0];
  end

  assign rem = rem_s[W];

endmodule

// File: rtl/aa_psw.sv
module aa_psw
  import accum_alu_pkg::*;
#(
  parameter int W         = 8,
  parameter int RAM_AW    = 8,
  parameter int BANK_REGS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flag_upd,
  input  arith_flags_t      flags_in,
  input  logic              wr_en,
  input  logic [PSW_W-1:0]  wr_data,
  input  logic [W-1:0]      acc_in,
  output logic [PSW_W-1:0]  psw_q,
  output logic [RAM_AW-1:0] bank_base
);
  localparam int BANK_SH = $clog2(BANK_REGS);

  logic       cy_q, ac_q, ov_q, f0_q, f1_q, par_q;
  logic [1:0] rs_q;
  logic       unused_par_wr;

  assign unused_par_wr = wr_data[PSW_P];

  always_ff @(posedge clk) begin
    if (rst) begin
      cy_q  <= 1'b0;
      ac_q  <= 1'b0;
      ov_q  <= 1'b0;
      f0_q  <= 1'b0;
      f1_q  <= 1'b0;
      rs_q  <= 2'b00;
      par_q <= 1'b0;
    end else begin
      if (wr_en) begin
        cy_q <= wr_data[PSW_CY];
        ac_q <= wr_data[PSW_AC];
        f0_q <= wr_data[PSW_F0];
        rs_q <= {wr_data[PSW_RS1], wr_data[PSW_RS0]};
        ov_q <= wr_data[PSW_OV];
        f1_q <= wr_data[PSW_F1];
      end
      // arithmetic result overrides a same-cycle software write
      if (flag_upd) begin
        cy_q <= flags_in.cy;
        ac_q <= flags_in.ac;
        ov_q <= flags_in.ov;
      end
      par_q <= ^acc_in;
    end
  end

  always_comb begin
    psw_q          = '0;
    psw_q[PSW_CY]  = cy_q;
    psw_q[PSW_AC]  = ac_q;
    psw_q[PSW_F0]  = f0_q;
    psw_q[PSW_RS1] = rs_q[1];
    psw_q[PSW_RS0] = rs_q[0];
    psw_q[PSW_OV]  = ov_q;
    psw_q[PSW_F1]  = f1_q;
    psw_q[PSW_P]   = par_q;
  end

  assign bank_base = RAM_AW'({rs_q, {BANK_SH{1'b0}}});

  // R8: parity tracks the accumulator seen one edge earlier
  p_parity_follows_acc_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> psw_q[PSW_P] == ^$past(acc_in));

  // R12: user flags and bank select only move on a write
  p_user_bits_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable({f0_q, f1_q, rs_q}));

endmodule

// File: rtl/accum_alu.sv
module accum_alu
  import accum_alu_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RAM_AW    = 8,
  parameter int BANK_REGS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              psw_we,
  input  logic [7:0]        psw_wdata,
  output logic [DATA_W-1:0] res_acc,
  output logic [DATA_W-1:0] res_b,
  output logic              res_acc_we,
  output logic              res_b_we,
  output logic [7:0]        psw_out,
  output logic [RAM_AW-1:0] bank_base
);
  logic [DATA_W-1:0]   as_res;
  logic                as_cy, as_ac, as_ov;
  logic [2*DATA_W-1:0] prod;
  logic [DATA_W-1:0]   quo, rem;
  logic                div_zero;

  logic                is_add, is_addc, is_sub, is_mul, is_div, take;
  arith_flags_t        nxt_flags;
  logic [DATA_W-1:0]   nxt_acc, nxt_b;
  logic                nxt_acc_we, nxt_b_we;

  always_comb begin
    is_add  = op_valid && (op_code == OP_ADD);
    is_addc = op_valid && (op_code == OP_ADDC);
    is_sub  = op_valid && (op_code == OP_SUBB);
    is_mul  = op_valid && (op_code == OP_MUL);
    is_div  = op_valid && (op_code == OP_DIV);
    take    = is_add | is_addc | is_sub | is_mul | is_div;
  end

  aa_addsub #(.W(DATA_W)) u_addsub (
    .sub (is_sub),
    .cin ((is_addc | is_sub) & psw_out[PSW_CY]),
    .a   (acc_in),
    .b   (opnd_in),
    .res (as_res),
    .cy  (as_cy),
    .ac  (as_ac),
    .ov  (as_ov)
  );

  aa_muldiv #(.W(DATA_W)) u_muldiv (
    .a        (acc_in),
    .d        (b_in),
    .prod     (prod),
    .quo      (quo),
    .rem      (rem),
    .div_zero (div_zero)
  );

  always_comb begin
    nxt_flags  = '0;
    nxt_acc    = as_res;
    nxt_b      = prod[2*DATA_W-1:DATA_W];
    nxt_acc_we = 1'b0;
    nxt_b_we   = 1'b0;
    if (is_add || is_addc || is_sub) begin
      nxt_flags  = '{cy: as_cy, ac: as_ac, ov: as_ov};
      nxt_acc_we = 1'b1;
    end else if (is_mul) begin
      nxt_flags.ov = |prod[2*DATA_W-1:DATA_W];
      nxt_acc      = prod[DATA_W-1:0];
      nxt_acc_we   = 1'b1;
      nxt_b_we     = 1'b1;
    end else if (is_div) begin
      nxt_flags.ov = div_zero;
      nxt_acc      = quo;
      nxt_b        = rem;
      nxt_acc_we   = !div_zero;
      nxt_b_we     = !div_zero;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_acc    <= '0;
      res_b      <= '0;
      res_acc_we <= 1'b0;
      res_b_we   <= 1'b0;
    end else begin
      res_acc_we <= nxt_acc_we;
      res_b_we   <= nxt_b_we;
      if (nxt_acc_we) res_acc <= nxt_acc;
      if (nxt_b_we)   res_b   <= nxt_b;
    end
  end

  aa_psw #(
    .W         (DATA_W),
    .RAM_AW    (RAM_AW),
    .BANK_REGS (BANK_REGS)
  ) u_psw (
    .clk       (clk),
    .rst       (rst),
    .flag_upd  (take),
    .flags_in  (nxt_flags),
    .wr_en     (psw_we),
    .wr_data   (psw_wdata),
    .acc_in    (acc_in),
    .psw_q     (psw_out),
    .bank_base (bank_base)
  );

  // R7: zero divisor raises OV and suppresses write-back
  p_div_zero_no_write_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_DIV && b_in == '0)
      |=> (!res_acc_we && !res_b_we && psw_out[PSW_OV] && !psw_out[PSW_CY]));

  // R5: multiply overflow flag agrees with the written high byte
  p_mul_ov_matches_high_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_MUL)
      |=> (res_b_we && (psw_out[PSW_OV] == (res_b != '0))));

  // R13: a B write is always accompanied by an accumulator write
  p_b_write_pairs_r13: assert property (@(posedge clk) disable iff (rst)
    res_b_we |-> res_acc_we);

  // R12: idle cycles leave flags and strobes quiet
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !psw_we)
      |=> (!res_acc_we && !res_b_we && $stable(psw_out[7:1])));

endmodule

// File: tb/accum_alu_tb.sv
`timescale 1ns/1ps
module accum_alu_tb;
  localparam int DW = 8;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 1'b0;
  logic [2:0]    op_code = '0;
  logic [DW-1:0] acc_in = '0, opnd_in = '0, b_in = '0;
  logic          psw_we = 1'b0;
  logic [7:0]    psw_wdata = '0;
  logic [DW-1:0] res_acc, res_b;
  logic          res_acc_we, res_b_we;
  logic [7:0]    psw_out;
  logic [AW-1:0] bank_base;

  int n_tests = 0;
  int n_fail  = 0;
  bit live    = 1'b0;

  always #5 clk = ~clk;

  accum_alu #(.DATA_W(DW), .RAM_AW(AW), .BANK_REGS(8)) u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .acc_in(acc_in), .opnd_in(opnd_in), .b_in(b_in),
    .psw_we(psw_we), .psw_wdata(psw_wdata),
    .res_acc(res_acc), .res_b(res_b), .res_acc_we(res_acc_we),
    .res_b_we(res_b_we), .psw_out(psw_out), .bank_base(bank_base)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0] m_psw = 8'h00;
  int         m_acc = 0, m_b = 0;
  bit         m_awe = 0, m_bwe = 0;
  string      m_tag = "R1", m_ovtag = "R1", m_utag = "R1";

  always @(posedge clk) begin
    int a, o, bb, c, s, sa, so, sr;
    logic [7:0] np;
    if (rst) begin
      m_psw = 8'h00; m_awe = 0; m_bwe = 0;
      m_tag = "R1"; m_ovtag = "R1"; m_utag = "R1";
    end else begin
      a = int'(acc_in); o = int'(opnd_in); bb = int'(b_in); c = int'(m_psw[7]);
      np = m_psw; m_awe = 0; m_bwe = 0;
      m_tag = "R12"; m_ovtag = "R12"; m_utag = "R12";
      if (psw_we) begin
        np[7:1] = psw_wdata[7:1];
        m_tag = "R9"; m_ovtag = "R9"; m_utag = "R9";
      end
      if (op_valid && op_code <= 3'd4) begin
        if (psw_we) m_utag = "R10";
        sa = (a >= 128) ? a - 256 : a;
        so = (o >= 128) ? o - 256 : o;
        case (op_code)
          3'd0, 3'd1: begin
            if (op_code == 3'd0) c = 0;
            s = a + o + c;
            m_acc = s % 256; m_awe = 1;
            np[7] = (s > 255);
            np[6] = ((a % 16) + (o % 16) + c) > 15;
            sr = sa + so + c;
            np[2] = (sr > 127) || (sr < -128);
            m_tag = "R2"; m_ovtag = "R4";
          end
          3'd2: begin
            s = a - o - c;
            m_acc = (s < 0) ? s + 256 : s; m_awe = 1;
            np[7] = (s < 0);
            np[6] = ((a % 16) - (o % 16) - c) < 0;
            sr = sa - so - c;
            np[2] = (sr > 127) || (sr < -128);
            m_tag = "R3"; m_ovtag = "R4";
          end
          3'd3: begin
            s = a * bb;
            m_acc = s % 256; m_b = s / 256; m_awe = 1; m_bwe = 1;
            np[7] = 0; np[6] = 0; np[2] = (s > 255);
            m_tag = "R5"; m_ovtag = "R5";
          end
          default: begin
            np[7] = 0; np[6] = 0;
            if (bb == 0) begin
              np[2] = 1; m_tag = "R7"; m_ovtag = "R7";
            end else begin
              np[2] = 0; m_acc = a / bb; m_b = a % bb; m_awe = 1; m_bwe = 1;
              m_tag = "R6"; m_ovtag = "R6";
            end
          end
        endcase
        if (psw_we) begin
          m_tag = {m_tag, "/R10"}; m_ovtag = {m_ovtag, "/R10"};
        end
      end
      np[0] = ^acc_in;
      m_psw = np;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      check({m_tag, " CY/AC"}, int'(psw_out[7:6]), int'(m_psw[7:6]));
      check({m_ovtag, " OV"}, int'(psw_out[2]), int'(m_psw[2]));
      check({m_utag, " F0/RS/F1"}, int'({psw_out[5:3], psw_out[1]}),
            int'({m_psw[5:3], m_psw[1]}));
      check("R8 parity", int'(psw_out[0]), int'(m_psw[0]));
      check("R11 bank base", int'(bank_base), int'(m_psw[4:3]) * 8);
      check("R13 strobes", int'({res_acc_we, res_b_we}), int'({m_awe, m_bwe}));
      if (m_awe && res_acc_we) check({m_tag, " acc result"}, int'(res_acc), m_acc);
      if (m_bwe && res_b_we)   check({m_tag, " B result"}, int'(res_b), m_b);
    end
  end

  task automatic drive(input bit v, input int code, input int a, input int o,
                       input int bb, input bit we, input int wd);
    @(negedge clk);
    op_valid  = v;
    op_code   = 3'(code);
    acc_in    = DW'(a);
    opnd_in   = DW'(o);
    b_in      = DW'(bb);
    psw_we    = we;
    psw_wdata = 8'(wd);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 psw", int'(psw_out), 0);
    check("R1 bank", int'(bank_base), 0);
    check("R1 strobes", int'({res_acc_we, res_b_we}), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 psw after release", int'(psw_out), 0);
    live = 1'b1;

    // R2/R4 adds across nibble, sign and byte boundaries
    drive(1, 0, 8'h7F, 8'h01, 0, 0, 0);
    drive(1, 0, 8'hFF, 8'h01, 0, 0, 0);
    drive(1, 1, 8'h10, 8'h20, 0, 0, 0);   // ADDC with carry set
    drive(1, 0, 8'h80, 8'h80, 0, 0, 0);
    drive(1, 1, 8'h0E, 8'h01, 0, 0, 0);
    // R3/R4 subtracts
    drive(1, 2, 8'h80, 8'h01, 0, 0, 0);
    drive(1, 2, 8'h00, 8'h01, 0, 0, 0);
    drive(1, 2, 8'h10, 8'h0F, 0, 0, 0);   // borrow in from previous
    drive(1, 2, 8'h7F, 8'hFF, 0, 0, 0);
    // R5 multiply at the 255 limit
    drive(1, 3, 8'h0F, 0, 8'h11, 0, 0);
    drive(1, 3, 8'h10, 0, 8'h10, 0, 0);
    drive(1, 3, 8'hFF, 0, 8'hFF, 0, 0);
    // R6/R7 divide
    drive(1, 4, 8'hFF, 0, 8'h10, 0, 0);
    drive(1, 4, 8'h05, 0, 8'h07, 0, 0);
    drive(1, 4, 8'h42, 0, 8'h00, 0, 0);
    // R9/R11 status writes across all banks, parity bit ignored
    drive(0, 0, 8'h01, 0, 0, 1, 8'h01);
    drive(0, 0, 8'h03, 0, 0, 1, 8'h08);
    drive(0, 0, 8'h07, 0, 0, 1, 8'h10);
    drive(0, 0, 8'h00, 0, 0, 1, 8'hFF);
    // R10 write colliding with arithmetic
    drive(1, 0, 8'h01, 8'h01, 0, 1, 8'hE6);
    drive(1, 4, 8'h09, 0, 8'h00, 1, 8'h00);
    // R12 unused opcodes and idle
    drive(1, 5, 8'hAA, 8'h55, 8'h03, 0, 0);
    drive(1, 7, 8'h12, 8'h34, 8'h00, 0, 0);
    drive(0, 3, 8'hFF, 8'hFF, 8'hFF, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      drive($urandom_range(0, 99) < 85, $urandom_range(0, 7),
            $urandom_range(0, 255), $urandom_range(0, 255),
            ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(0, 255),
            $urandom_range(0, 99) < 20, $urandom_range(0, 255));
    end
    drive(0, 0, 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule